// File: doc/BRIEF.md
# Multi-Rate Codeword Sequencer

This block sequences one systematic block-code codeword at a time for an encoder with three selectable code rates. Information bits come in serially and are written into an internal synchronous FIFO. While they arrive, the block counts fixed-size segments. At the start of each segment it raises a strobe that tells the outside generator memories to load the next set of circulant polynomials. With the strobe it gives the segment number and a per-engine enable mask, which depends on the rate.

When the last information bit has been taken, the block waits for the external parity engines to report completion. It then captures all parity groups in one cycle and shifts them out serially, less the first few parity bits. Without a gap, it then replays the buffered information bits from the FIFO. The input is closed from the final information bit until the last code bit of that codeword is on the output. Each codeword therefore leaves as one unbroken burst of a fixed number of bits, whatever the rate.

Top module: `cws_sequencer`

## Requirements
- R1: `rate_sel` is decoded as 2'b00 → K_R0 segments / C_R0 engines, 2'b01 → K_R1 / C_R1, 2'b10 or 2'b11 → K_R2 / C_R2. It is sampled only together with the first accepted information bit of a codeword, and later changes have no effect on that codeword.
- R2: After reset, and again in the cycle that presents the last code bit of a codeword, `info_ready` is high. It drops in the cycle after the K·SEG-th information bit is accepted and stays low until the next such last code bit.
- R3: `poly_load` is high, combinationally, in exactly those cycles in which an information bit whose position within its segment is 0 is accepted. At that time `poly_seg` holds the segment number, counted from 0.
- R4: When `poly_load` is high, `mem_en` has bits 0 to C−1 set and all others clear, where C is the engine count of the codeword's rate. When `poly_load` is low, `mem_en` is all zero.
- R5: `par_done` is acted on only after the information bits are complete and while no code bits are pending. A pulse at any other time, including the cycle that accepts the last information bit, has no effect.
- R6: The first C·SEG−DROP output bits are bits DROP to C·SEG−1 of `par_groups`, taken in ascending bit order, as captured in the cycle `par_done` was taken. Group g occupies bits g·SEG to g·SEG+SEG−1.
- R7: The parity bits are followed directly by the K·SEG information bits, in the order they were accepted.
- R8: `code_valid` is high for exactly (K+C)·SEG−DROP consecutive cycles per codeword, beginning two cycles after the cycle in which `par_done` is taken. `code_bit` is 0 whenever `code_valid` is low.
- R9: Out of reset, `code_valid`, `code_bit` and `poly_load` are 0 and `info_ready` is 1.
- R10: Changes to `par_groups` after the capture cycle do not alter the emitted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Code rate choice, sampled with the first information bit |
| info_bit | input | 1 | Serial information bit |
| info_valid | input | 1 | Information bit present |
| info_ready | output | 1 | Information bit accepted when high together with info_valid |
| poly_load | output | 1 | Generator polynomial load strobe, once per segment |
| poly_seg | output | $clog2(K_R2) | Segment number for the load |
| mem_en | output | C_R0 | Per-engine generator memory enables |
| par_groups | input | C_R0·SEG | Parallel parity groups from the engines |
| par_done | input | 1 | Parity engines finished |
| code_bit | output | 1 | Serial codeword bit |
| code_valid | output | 1 | Codeword bit present |

## Verification
Two events can land in the same cycle: the last information bit is accepted while a parity-done pulse arrives. The block must take the bit, close its input, and ignore the pulse. The bench provokes this on half of its codewords by raising `par_done` with the final bit. It then checks that no output starts and that the input stays closed until a later, proper pulse. The same bench also checks the other overlap: `info_ready` rises in the very cycle that carries the last code bit. This is judged beat by beat across every rate encoding, with and without input gaps.

// File: rtl/cws_pkg.sv
// Shared types for the codeword sequencer.
// Assumes: rate code 2'b11 is treated like 2'b10.
package cws_pkg;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'b00,
        RATE_MID  = 2'b01,
        RATE_HIGH = 2'b10
    } rate_e;

    typedef enum logic [1:0] {
        PH_LOAD = 2'b00,
        PH_WAIT = 2'b01,
        PH_PAR  = 2'b10,
        PH_INFO = 2'b11
    } phase_e;

    // Map the raw select pins onto a rate; the unused code folds onto the highest rate.
    function automatic rate_e decode_rate(input logic [1:0] sel);
        case (sel)
            2'b00:   return RATE_LOW;
            2'b01:   return RATE_MID;
            default: return RATE_HIGH;
        endcase
    endfunction

endpackage

// File: rtl/cws_seg_ctrl.sv
// Segment counter for the information input.
// Counts accepted bits within a segment and segments within a codeword, raises the
// polynomial load strobe at each segment start, and builds the per-engine enables.
// Assumes: SEG >= 2, KMAX >= 2; k_sel/c_sel are held stable for the codeword.
module cws_seg_ctrl #(
    parameter int SEG  = 127,
    parameter int KMAX = 48,
    parameter int CMAX = 35,
    localparam int BW  = $clog2(SEG),
    localparam int SCW = $clog2(KMAX),
    localparam int KW  = $clog2(KMAX + 1),
    localparam int CW  = $clog2(CMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [KW-1:0]   k_sel,
    input  logic [CW-1:0]   c_sel,
    output logic            cw_start,
    output logic            poly_load,
    output logic [SCW-1:0]  poly_seg,
    output logic [CMAX-1:0] mem_en,
    output logic            load_done
);

    logic [BW-1:0]  bit_q;
    logic [SCW-1:0] seg_q;
    logic           bit_last;
    logic           seg_last;

    assign bit_last  = (bit_q == BW'(SEG - 1));
    assign seg_last  = ({1'b0, seg_q} == (SCW + 1)'(k_sel - KW'(1)));
    assign cw_start  = (bit_q == '0) && (seg_q == '0);
    assign poly_load = accept && (bit_q == '0);
    assign poly_seg  = seg_q;
    assign load_done = accept && bit_last && seg_last;

    // Advance the bit and segment counters on every accepted information bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            seg_q <= '0;
        end else if (accept) begin
            if (bit_last) begin
                bit_q <= '0;
                seg_q <= seg_last ? '0 : seg_q + SCW'(1);
            end else begin
                bit_q <= bit_q + BW'(1);
            end
        end
    end

    // One enable per parity engine: active with the strobe when the engine serves this rate.
    for (genvar g = 0; g < CMAX; g++) begin : g_en
        assign mem_en[g] = poly_load && (CW'(g) < c_sel);
    end

    // R3: a load never names a segment beyond the rate's segment count.
    assert_seg_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        poly_load |-> ({1'b0, poly_seg} < (SCW + 1)'(k_sel)));

endmodule

// File: rtl/cws_info_fifo.sv
// Synchronous FIFO for one codeword of information bits.
// Storage is packed into WORD_W-bit words with bit-granular writes; read data is
// presented combinationally at the read pointer. A clear returns both pointers to 0.
// Assumes: WORD_W is a power of two >= 2 and at least two words are needed.
module cws_info_fifo #(
    parameter int DEPTH  = 6096,
    parameter int WORD_W = 64,
    localparam int NW    = (DEPTH + WORD_W - 1) / WORD_W,
    localparam int LW    = $clog2(WORD_W),
    localparam int WIW   = $clog2(NW),
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic wr_en,
    input  logic wr_data,
    input  logic rd_en,
    output logic rd_data
);

    logic [WORD_W-1:0] mem [NW];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic [WIW-1:0]    wr_word;
    logic [WIW-1:0]    rd_word;
    logic [LW-1:0]     wr_bit;
    logic [LW-1:0]     rd_bit;

    assign wr_word = WIW'(wr_ptr >> LW);
    assign rd_word = WIW'(rd_ptr >> LW);
    assign wr_bit  = wr_ptr[LW-1:0];
    assign rd_bit  = rd_ptr[LW-1:0];
    assign rd_data = mem[rd_word][rd_bit];

    // Store one bit at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_word][wr_bit] <= wr_data;
        end
    end

    // Move the pointers; a clear wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + PW'(1);
            if (rd_en) rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // R7: writes stay inside one codeword's worth of storage.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ptr < PW'(DEPTH)));

    // R7: the replay never reads a bit that was not written.
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_ptr != wr_ptr));

endmodule

// File: rtl/cws_par_ser.sv
// Parity parallel-to-serial converter.
// Captures all parity groups at once, already advanced past the dropped bits, then
// shifts one bit per cycle toward bit 0.
// Assumes: capture and shift are never requested together.
module cws_par_ser #(
    parameter int W    = 4445,
    parameter int DROP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    output logic         ser_bit
);

    logic [W-1:0] sr_q;

    assign ser_bit = sr_q[0];

    // Load the parity image without its leading bits, or shift it down one place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (capture) begin
            sr_q <= par_in >> DROP;
        end else if (shift) begin
            sr_q <= sr_q >> 1;
        end
    end

    // R5: a capture never lands while parity bits are still being emitted.
    assert_capture_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !shift);

endmodule

// File: rtl/cws_sequencer.sv
// Multi-rate codeword sequencer (top).
// Accepts information bits, drives segment load strobes and engine enables, waits for
// parity completion, then emits parity (minus the first DROP bits) followed by the
// buffered information bits as one unbroken burst.
// Assumes: K_Rx + C_Rx is the same for all three rates; C_R0 >= C_R1 >= C_R2 and
// K_R2 is the largest segment count; DROP < C_R2 * SEG.
module cws_sequencer #(
    parameter int SEG    = 127,
    parameter int K_R0   = 24,
    parameter int K_R1   = 36,
    parameter int K_R2   = 48,
    parameter int C_R0   = 35,
    parameter int C_R1   = 23,
    parameter int C_R2   = 11,
    parameter int DROP   = 5,
    parameter int FIFO_W = 64,
    localparam int KMAX  = K_R2,
    localparam int CMAX  = C_R0,
    localparam int SCW   = $clog2(KMAX),
    localparam int KW    = $clog2(KMAX + 1),
    localparam int CW    = $clog2(CMAX + 1),
    localparam int NOUT  = (K_R0 + C_R0) * SEG - DROP,
    localparam int OW    = $clog2(NOUT),
    localparam int NPAR0 = C_R0 * SEG - DROP,
    localparam int NPAR1 = C_R1 * SEG - DROP,
    localparam int NPAR2 = C_R2 * SEG - DROP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          rate_sel,
    input  logic                info_bit,
    input  logic                info_valid,
    output logic                info_ready,
    output logic                poly_load,
    output logic [SCW-1:0]      poly_seg,
    output logic [CMAX-1:0]     mem_en,
    input  logic [CMAX*SEG-1:0] par_groups,
    input  logic                par_done,
    output logic                code_bit,
    output logic                code_valid
);
    import cws_pkg::*;

    phase_e        ph_q;
    rate_e         rate_q;
    rate_e         rate_cur;
    logic [OW-1:0] out_idx_q;
    logic [OW-1:0] npar_m1;
    logic [KW-1:0] k_cur;
    logic [CW-1:0] c_cur;
    logic          accept;
    logic          cw_start;
    logic          load_done;
    logic          par_take;
    logic          ser_bit;
    logic          fifo_rd_data;
    logic          fifo_rd;
    logic          fifo_clr;
    logic          last_out;
    logic          last_par;

    assign info_ready = (ph_q == PH_LOAD);
    assign accept     = info_valid && info_ready;
    assign par_take   = (ph_q == PH_WAIT) && par_done;
    assign last_par   = (out_idx_q == npar_m1);
    assign last_out   = (out_idx_q == OW'(NOUT - 1));
    assign fifo_rd    = (ph_q == PH_INFO);
    assign fifo_clr   = fifo_rd && last_out;

    // Rate in force: the pins on the first bit, the latched value afterwards.
    assign rate_cur = (info_ready && cw_start) ? decode_rate(rate_sel) : rate_q;

    // Segment and engine counts for the rate in force.
    always_comb begin
        case (rate_cur)
            RATE_LOW: begin k_cur = KW'(K_R0); c_cur = CW'(C_R0); end
            RATE_MID: begin k_cur = KW'(K_R1); c_cur = CW'(C_R1); end
            default:  begin k_cur = KW'(K_R2); c_cur = CW'(C_R2); end
        endcase
    end

    // Index of the last emitted parity bit for the latched rate.
    always_comb begin
        case (rate_q)
            RATE_LOW: npar_m1 = OW'(NPAR0 - 1);
            RATE_MID: npar_m1 = OW'(NPAR1 - 1);
            default:  npar_m1 = OW'(NPAR2 - 1);
        endcase
    end

    // Latch the rate with the first information bit of each codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_LOW;
        end else if (accept && cw_start) begin
            rate_q <= decode_rate(rate_sel);
        end
    end

    // Phase sequencing and the registered serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_LOAD;
            out_idx_q  <= '0;
            code_bit   <= 1'b0;
            code_valid <= 1'b0;
        end else begin
            case (ph_q)
                PH_LOAD: begin
                    code_bit   <= 1'b0;
                    code_valid <= 1'b0;
                    if (load_done) ph_q <= PH_WAIT;
                end
                PH_WAIT: begin
                    code_bit   <= 1'b0;
                    code_valid <= 1'b0;
                    out_idx_q  <= '0;
                    if (par_done) ph_q <= PH_PAR;
                end
                PH_PAR: begin
                    code_bit   <= ser_bit;
                    code_valid <= 1'b1;
                    out_idx_q  <= out_idx_q + OW'(1);
                    if (last_par) ph_q <= PH_INFO;
                end
                default: begin
                    code_bit   <= fifo_rd_data;
                    code_valid <= 1'b1;
                    out_idx_q  <= out_idx_q + OW'(1);
                    if (last_out) ph_q <= PH_LOAD;
                end
            endcase
        end
    end

    cws_seg_ctrl #(
        .SEG  (SEG),
        .KMAX (KMAX),
        .CMAX (CMAX)
    ) u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .k_sel     (k_cur),
        .c_sel     (c_cur),
        .cw_start  (cw_start),
        .poly_load (poly_load),
        .poly_seg  (poly_seg),
        .mem_en    (mem_en),
        .load_done (load_done)
    );

    cws_info_fifo #(
        .DEPTH  (KMAX * SEG),
        .WORD_W (FIFO_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .wr_en   (accept),
        .wr_data (info_bit),
        .rd_en   (fifo_rd),
        .rd_data (fifo_rd_data)
    );

    cws_par_ser #(
        .W    (CMAX * SEG),
        .DROP (DROP)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (par_take),
        .shift   (ph_q == PH_PAR),
        .par_in  (par_groups),
        .ser_bit (ser_bit)
    );

    // R2: once the last information bit is in, the input closes on the next cycle.
    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !info_ready);

    // R2: input reopening coincides with the final beat of the burst.
    assert_ready_on_last_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (info_ready && code_valid) |=> !code_valid);

    // R8: a burst only ends once the input has reopened.
    assert_burst_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(code_valid) |-> info_ready);

    // R5: parity is taken only while the input is closed and the output is idle.
    assert_take_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        par_take |-> (!info_ready && !code_valid));

endmodule

// File: tb/tb_cws_sequencer.sv
module tb_cws_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int SEG  = 4;
    localparam int DROP = 5;
    localparam int CMAX = 5;
    localparam int NOUT = 7 * SEG - DROP;
    localparam int WDOG = 20000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          rate_sel = 2'b00;
    logic                info_bit = 1'b0;
    logic                info_valid = 1'b0;
    logic                info_ready;
    logic                poly_load;
    logic [1:0]          poly_seg;
    logic [CMAX-1:0]     mem_en;
    logic [CMAX*SEG-1:0] par_groups = '0;
    logic                par_done = 1'b0;
    logic                code_bit;
    logic                code_valid;

    int nvec = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cws_sequencer #(
        .SEG(SEG), .K_R0(2), .K_R1(3), .K_R2(4),
        .C_R0(5), .C_R1(4), .C_R2(3), .DROP(DROP), .FIFO_W(4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .info_bit(info_bit),
        .info_valid(info_valid), .info_ready(info_ready), .poly_load(poly_load),
        .poly_seg(poly_seg), .mem_en(mem_en), .par_groups(par_groups),
        .par_done(par_done), .code_bit(code_bit), .code_valid(code_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int k_of(input int rs);
        return (rs == 0) ? 2 : (rs == 1) ? 3 : 4;
    endfunction

    function automatic int c_of(input int rs);
        return (rs == 0) ? 5 : (rs == 1) ? 4 : 3;
    endfunction

    // One codeword: rate code rs, bit pattern from seed, optional input gaps, and
    // optionally a stray parity-done pulse together with the last information bit.
    task automatic run_cw(input int rs, input int seed, input bit gaps, input bit early);
        int nin = k_of(rs) * SEG;
        int c = c_of(rs);
        int npar = c * SEG - DROP;
        logic [15:0] ib;
        logic [CMAX*SEG-1:0] pp;
        int i = 0;
        int slot = 0;
        for (int j = 0; j < 16; j++) ib[j] = 1'(((j * 5 + seed) >> 1) ^ j);
        for (int j = 0; j < CMAX * SEG; j++) pp[j] = (((j * 3 + seed * 7) % 5) < 2);
        rate_sel = 2'(rs);
        while (i < nin) begin
            @(negedge clk);
            if (gaps && (slot % 3 == 2)) begin
                info_valid = 1'b0;
                par_done = 1'b0;
                #1;
                check(poly_load == 1'b0, "R3 idle strobe", int'(poly_load), 0);
                slot++;
                continue;
            end
            if (i >= 1) rate_sel = 2'(~rs);  // R1: later changes must be ignored
            info_valid = 1'b1;
            info_bit = ib[i];
            par_done = early && (i == nin - 1);  // R5: stray pulse on the last bit
            #1;
            check(info_ready == 1'b1, "R2 open during load", int'(info_ready), 1);
            check(poly_load == (i % SEG == 0), "R3 strobe", int'(poly_load), int'(i % SEG == 0));
            if (i % SEG == 0) begin
                check(int'(poly_seg) == i / SEG, "R3 segment", int'(poly_seg), i / SEG);
                check(int'(mem_en) == (1 << c) - 1, "R4 enables", int'(mem_en), (1 << c) - 1);
            end else begin
                check(mem_en == '0, "R4 enables quiet", int'(mem_en), 0);
            end
            i++;
            slot++;
        end
        @(negedge clk);
        info_valid = 1'b0;
        par_done = 1'b0;
        for (int w = 0; w < 3; w++) begin
            check(info_ready == 1'b0, "R2 closed after load", int'(info_ready), 0);
            check(code_valid == 1'b0 && code_bit == 1'b0, "R5 R8 no output before done",
                  int'(code_valid), 0);
            @(negedge clk);
        end
        par_groups = pp;
        par_done = 1'b1;
        @(negedge clk);
        par_done = 1'b0;
        par_groups = ~pp;  // R10: late change must not matter
        check(code_valid == 1'b0, "R8 start delay", int'(code_valid), 0);
        for (int j = 0; j < NOUT; j++) begin
            logic expb;
            @(negedge clk);
            expb = (j < npar) ? pp[DROP + j] : ib[j - npar];
            check(code_valid == 1'b1, "R8 burst", int'(code_valid), 1);
            check(code_bit == expb, (j < npar) ? "R6 R10 parity bit" : "R7 info bit",
                  int'(code_bit), int'(expb));
            check(info_ready == (j == NOUT - 1), "R2 reopen", int'(info_ready),
                  int'(j == NOUT - 1));
        end
        @(negedge clk);
        check(code_valid == 1'b0 && code_bit == 1'b0, "R8 burst length", int'(code_valid), 0);
        check(info_ready == 1'b1, "R2 open between codewords", int'(info_ready), 1);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(info_ready == 1'b1, "R9 reset ready", int'(info_ready), 1);
        check(code_valid == 1'b0, "R9 reset valid", int'(code_valid), 0);
        check(code_bit == 1'b0, "R9 reset bit", int'(code_bit), 0);
        check(poly_load == 1'b0, "R9 reset strobe", int'(poly_load), 0);
        for (int rs = 0; rs < 4; rs++) begin
            for (int m = 0; m < 2; m++) begin
                run_cw(rs, rs * 2 + m + 1, m == 1, m == 1);  // R1 every rate code
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule